// File: doc/BRIEF.md
# Cascaded ADC Timing Tick Generator

This block turns the input clock into three clock-enable strobes for a sampling converter. The first is a conversion-clock enable at a programmable fraction of the input rate. The other two are slower timing ticks, nominally one every 10 µs and one every 1 ms. All three are single-cycle pulses in the input clock domain. No clock is gated or muxed. Both timing ticks count conversion-clock enables, not input cycles, so each tick pulse coincides with a conversion enable.

All divisors come from one 32-bit configuration word written through a simple write strobe. Each field stores its divisor minus one, so a field value of 0 means divide by 1. Any write restarts every counter from a known phase. Software usually picks the smallest conversion divisor that keeps the conversion rate at or below its ceiling, which is 200 kHz in the default layout. It then rounds the tick divisors up so that no tick period is shorter than its nominal time.

A parameter selects one of two packings. The full layout has three fields. The short layout has a narrower conversion field, suited to conversion rates in the MHz range, and drops the 1 ms tick entirely. A power-down input holds the generator idle.

Top module: `adc_tick_gen`

## Requirements
- R1: Reset is synchronous and active high. While it is applied, all three outputs are low. After reset, the stored divisors are all zero (divide by 1), so `conv_en` and both ticks pulse in every cycle from the first clock edge after release.
- R2: In the full layout, `conv_en` pulses for one cycle once every (cfg bits [7:0] + 1) input cycles. Conversion divisors therefore run from 1 to 256.
- R3: `tick_10us` pulses on every (cfg bits [15:8] + 1)-th `conv_en` pulse (full layout), in the same cycle as that `conv_en` pulse.
- R4: `tick_1ms` pulses on every (cfg bits [23:16] + 1)-th `conv_en` pulse. Its count runs independently of `tick_10us` and is counted in `conv_en` pulses.
- R5: A cycle with `cfg_we` high stores the new divisors and clears every counter. All outputs are low in the following cycle. The first `conv_en` comes on the clock edge that is (conversion divisor) edges after the write edge.
- R6: With LAYOUT = LAYOUT_SHORT, the conversion divisor is cfg bits [5:0] + 1 (1 to 64) and the 10 µs divisor is cfg bits [23:16] + 1. Bits [15:6] have no effect, and `tick_1ms` stays low.
- R7: While `pwr_down` is high, all counters are held at zero and no output pulses. After release, counting restarts from zero, just as after a write.
- R8: Neither tick is ever high in a cycle in which `conv_en` is low.
- R9: In the full layout, cfg bits [31:24] have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock; all outputs are enables in this domain |
| rst | input | 1 | Synchronous active-high reset |
| pwr_down | input | 1 | Holds all counters at zero and suppresses all pulses |
| cfg_we | input | 1 | Write strobe for the divider word |
| cfg_wdata | input | 32 | Packed divider word, each field holding divisor minus one |
| conv_en | output | 1 | Single-cycle conversion-clock enable |
| tick_10us | output | 1 | Single-cycle 10 µs tick, coincident with a `conv_en` pulse |
| tick_1ms | output | 1 | Single-cycle 1 ms tick, coincident with a `conv_en` pulse (always low in the short layout) |

## Verification
The bench builds two copies side by side, one with LAYOUT_FULL and one with LAYOUT_SHORT. Both are fed the same writes, so a single word exercises both packings at once. That includes the bits the short layout must ignore and the top byte the full layout must ignore. A behavioural model follows cycles since restart and conversion pulses since restart, and checks all six outputs on every clock. This covers divide by 1, the 256 limit and mid-run rewrites. It also checks the restart phase after a write and after power-down.

// File: rtl/adc_tick_pkg.sv
package adc_tick_pkg;

  typedef enum logic {
    LAYOUT_FULL  = 1'b0,
    LAYOUT_SHORT = 1'b1
  } layout_e;

  localparam int CFG_W  = 32;
  localparam int DIV_W  = 8;
  localparam int MS_LSB = 16;

  function automatic int conv_width(layout_e l);
    return (l == LAYOUT_FULL) ? 8 : 6;
  endfunction

  function automatic int tick_lsb(layout_e l);
    return (l == LAYOUT_FULL) ? 8 : 16;
  endfunction

endpackage

// File: rtl/adc_tick_stage.sv
module adc_tick_stage #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             step,
  input  logic [CNT_W-1:0] div,
  output logic             strobe,
  output logic             pulse
);

  logic [CNT_W-1:0] cnt;
  logic             at_top;

  assign at_top = (cnt == div);
  assign strobe = step && !clr && at_top;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt   <= '0;
      pulse <= 1'b0;
    end else begin
      pulse <= strobe;
      if (step) begin
        cnt <= at_top ? '0 : cnt + 1'b1;
      end
    end
  end

  // R2
  pulse_gap_chk: assert property (@(posedge clk) disable iff (rst)
    (pulse && div != '0 && !clr) |=> !pulse);

endmodule

// File: rtl/adc_tick_gen.sv
module adc_tick_gen
  import adc_tick_pkg::*;
#(
  parameter layout_e LAYOUT = LAYOUT_FULL
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pwr_down,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_wdata,
  output logic             conv_en,
  output logic             tick_10us,
  output logic             tick_1ms
);

  localparam int  CONV_W = conv_width(LAYOUT);
  localparam int  T10_LSB = tick_lsb(LAYOUT);
  localparam bit  HAS_MS = (LAYOUT == LAYOUT_FULL);
  localparam logic [DIV_W-1:0] CONV_MASK = DIV_W'((1 << CONV_W) - 1);

  logic [DIV_W-1:0] conv_q;
  logic [DIV_W-1:0] t10_q;
  logic             clr;
  logic             conv_strobe;
  logic             unused_t10_strobe;
  logic             unused_wdata;

  assign clr          = cfg_we | pwr_down;
  assign unused_wdata = ^cfg_wdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      conv_q <= '0;
      t10_q  <= '0;
    end else if (cfg_we) begin
      conv_q <= cfg_wdata[DIV_W-1:0] & CONV_MASK;
      t10_q  <= cfg_wdata[T10_LSB +: DIV_W];
    end
  end

  adc_tick_stage #(.CNT_W(DIV_W)) u_conv (
    .clk    (clk),
    .rst    (rst),
    .clr    (clr),
    .step   (1'b1),
    .div    (conv_q),
    .strobe (conv_strobe),
    .pulse  (conv_en)
  );

  adc_tick_stage #(.CNT_W(DIV_W)) u_t10 (
    .clk    (clk),
    .rst    (rst),
    .clr    (clr),
    .step   (conv_strobe),
    .div    (t10_q),
    .strobe (unused_t10_strobe),
    .pulse  (tick_10us)
  );

  generate
    if (HAS_MS) begin : g_ms
      logic [DIV_W-1:0] ms_q;
      logic             unused_ms_strobe;

      always_ff @(posedge clk) begin
        if (rst) begin
          ms_q <= '0;
        end else if (cfg_we) begin
          ms_q <= cfg_wdata[MS_LSB +: DIV_W];
        end
      end

      adc_tick_stage #(.CNT_W(DIV_W)) u_ms (
        .clk    (clk),
        .rst    (rst),
        .clr    (clr),
        .step   (conv_strobe),
        .div    (ms_q),
        .strobe (unused_ms_strobe),
        .pulse  (tick_1ms)
      );

      // R8
      ms_in_conv_chk: assert property (@(posedge clk) disable iff (rst)
        tick_1ms |-> conv_en);
    end else begin : g_no_ms
      assign tick_1ms = 1'b0;
    end
  endgenerate

  // R8
  t10_in_conv_chk: assert property (@(posedge clk) disable iff (rst)
    tick_10us |-> conv_en);

  // R7
  pd_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    pwr_down |=> (!conv_en && !tick_10us && !tick_1ms));

  // R5
  write_restart_chk: assert property (@(posedge clk) disable iff (rst)
    cfg_we |=> (!conv_en && !tick_10us && !tick_1ms));

endmodule

// File: tb/adc_tick_gen_bench.sv
module adc_tick_gen_bench;
  import adc_tick_pkg::*;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        pd  = 1'b0;
  logic        we  = 1'b0;
  logic [31:0] wd  = '0;
  logic f_conv, f_t10, f_ms, s_conv, s_t10, s_ms;

  int  checks = 0;
  int  fails  = 0;
  bit  done   = 1'b0;
  bit  started = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_tick_gen #(.LAYOUT(LAYOUT_FULL)) u_adc_tick_gen (
    .clk(clk), .rst(rst), .pwr_down(pd), .cfg_we(we), .cfg_wdata(wd),
    .conv_en(f_conv), .tick_10us(f_t10), .tick_1ms(f_ms));

  adc_tick_gen #(.LAYOUT(LAYOUT_SHORT)) u_adc_tick_gen_short (
    .clk(clk), .rst(rst), .pwr_down(pd), .cfg_we(we), .cfg_wdata(wd),
    .conv_en(s_conv), .tick_10us(s_t10), .tick_1ms(s_ms));

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s at %0t: actual %0d expected %0d", req, $time, act, exp);
    end
  endtask

  // behavioural model: cycles since restart and conversion pulses since restart
  int f_dm, f_d10, f_d1, f_n, f_m;
  int s_dm, s_d10, s_n, s_m;
  bit xf_conv, xf_t10, xf_ms, xs_conv, xs_t10;

  always @(posedge clk) begin
    started = 1'b1;
    if (rst) begin
      f_dm = 1; f_d10 = 1; f_d1 = 1; s_dm = 1; s_d10 = 1;
      f_n = 0; f_m = 0; s_n = 0; s_m = 0;
      xf_conv = 0; xf_t10 = 0; xf_ms = 0; xs_conv = 0; xs_t10 = 0;
    end else begin
      if (we) begin
        f_dm  = int'(wd[7:0]) + 1;
        f_d10 = int'(wd[15:8]) + 1;
        f_d1  = int'(wd[23:16]) + 1;
        s_dm  = int'(wd[5:0]) + 1;
        s_d10 = int'(wd[23:16]) + 1;
      end
      if (we || pd) begin
        f_n = 0; f_m = 0; s_n = 0; s_m = 0;
        xf_conv = 0; xf_t10 = 0; xf_ms = 0; xs_conv = 0; xs_t10 = 0;
      end else begin
        f_n++;
        xf_conv = (f_n % f_dm) == 0;
        if (xf_conv) f_m++;
        xf_t10 = xf_conv && ((f_m % f_d10) == 0);
        xf_ms  = xf_conv && ((f_m % f_d1) == 0);
        s_n++;
        xs_conv = (s_n % s_dm) == 0;
        if (xs_conv) s_m++;
        xs_t10 = xs_conv && ((s_m % s_d10) == 0);
      end
    end
  end

  always @(negedge clk) begin
    if (started && !done) begin
      check("R2 conv_en full", int'(f_conv), int'(xf_conv));
      check("R3 tick_10us full", int'(f_t10), int'(xf_t10));
      check("R4 tick_1ms full", int'(f_ms), int'(xf_ms));
      check("R6 conv_en short", int'(s_conv), int'(xs_conv));
      check("R6 tick_10us short", int'(s_t10), int'(xs_t10));
      check("R6 tick_1ms short", int'(s_ms), 0);
      check("R8 tick without conv_en", int'((f_t10 | f_ms) & ~f_conv), 0);
    end
  end

  task automatic run(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write_cfg(logic [31:0] v);
    @(negedge clk);
    we = 1'b1;
    wd = v;
    @(negedge clk);
    we = 1'b0;
  endtask

  initial begin
    run(3);
    check("R1 conv_en in reset", int'(f_conv), 0);
    check("R1 ticks in reset", int'(f_t10 | f_ms | s_conv | s_t10), 0);
    rst = 1'b0;
    run(2);
    check("R1 divide-by-1 after reset", int'(f_conv & f_t10 & f_ms), 1);
    run(10);

    write_cfg(32'h0006_0302);
    run(300);

    write_cfg(32'hA501_0200);
    run(1);
    check("R9 top byte ignored, div 1", int'(f_conv), 1);
    run(100);

    write_cfg(32'h0000_0505);
    run(7);
    write_cfg(32'h0000_0505);
    check("R5 quiet after write", int'(f_conv), 0);
    run(5);
    check("R5 no early conv_en", int'(f_conv), 0);
    run(1);
    check("R5 first conv_en at divisor", int'(f_conv), 1);
    run(100);

    @(negedge clk);
    pd = 1'b1;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      check("R7 power-down quiet", int'(f_conv | f_t10 | f_ms | s_conv | s_t10), 0);
    end
    pd = 1'b0;
    run(60);

    write_cfg(32'h0003_09C1);
    run(3000);

    write_cfg(32'h0001_00FF);
    run(1200);

    write_cfg(32'h0000_0000);
    run(20);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

endmodule